// File: doc/BRIEF.md
# Twelve-Function Nibble ALU

This is a purely combinational arithmetic-logic unit. It takes two operands, `x` and `y`, and a four-bit select word, `sel`. It returns a result `g` and a carry-out `cout`. The operand width is the parameter `W`, which defaults to 4.

There are two sections, and both evaluate on every input change. The arithmetic section is a single ripple adder. Its second operand is chosen from zero, `y`, the inverse of `y` or all ones, and its carry-in is `sel[0]`. These choices yield eight functions: pass, increment, add, add with carry, add with inverted operand, subtract, decrement and a second pass. The logic section performs four bitwise operations. A final two-way multiplexer, steered by `sel[3]`, keeps one section's result and discards the other.

A surrounding datapath uses the block wherever it needs a small combined adder and logic unit. For example, it can pick between incrementing an address and masking it.

Top module: `nib_alu`

## Requirements
- R1: When `sel[3]`=0, `g` is the arithmetic result. When `sel[3]`=1, `g` is the bitwise result.
- R2: With `sel[3]`=0, codes `sel[2:0]`=000 and 111 both give `g`=`x`. The carry-out is 0 for code 000 and 1 for code 111.
- R3: With `sel[3]`=0, code 001 gives `x`+1, code 010 gives `x`+`y`, and code 011 gives `x`+`y`+1.
- R4: With `sel[3]`=0, code 100 gives `x` plus the bitwise inverse of `y`, and code 101 gives that sum plus 1, which is `x`-`y`. For code 101, `cout` is 1 exactly when `x` >= `y`.
- R5: With `sel[3]`=0, code 110 gives `x`-1, computed as `x` plus all ones. Its `cout` is 1 unless `x`=0.
- R6: With `sel[3]`=1, `sel[1:0]` chooses the bitwise operation: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives the inverse of `x`. `sel[2]` has no effect on `g`.
- R7: With `sel[3]`=1, `cout` is 0.
- R8: Arithmetic results wrap modulo 2^W, and `cout` is bit W of the full sum. For example, `x`=1111 with `sel`=0001 gives `g`=0000 and `cout`=1.
- R9: The outputs depend only on the present inputs. They follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | W | First operand |
| y | input | W | Second operand |
| sel | input | 4 | Function select; bit 3 chooses the section |
| g | output | W | Result |
| cout | output | 1 | Adder carry-out; 0 for logic functions |

## Verification
The checker re-evaluates several properties whenever an input changes:
- The output multiplexer agrees with the section that `sel[3]` picks.
- `cout` stays low for logic functions.
- The carry and result together equal the full sum of `x`, the selected second operand and `sel[0]`.
- Both pass codes return `x`.
- The inverse-of-`x` code returns the inverse.

The correctness of each individual function code, the wrap-around corners and the independence from `sel[2]` are shown only by the bench. The bench sweeps every operand and select combination against its own arithmetic model.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  // Source of the adder's second operand, decoded from sel[2:1]
  typedef enum logic [1:0] {
    BSRC_ZERO = 2'b00,
    BSRC_Y    = 2'b01,
    BSRC_NOTY = 2'b10,
    BSRC_ONES = 2'b11
  } bsrc_e;

  // Bitwise operation, decoded from sel[1:0]
  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTX = 2'b11
  } lop_e;

  localparam int SEL_W = 4;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

  function automatic logic bsel_bit(input bsrc_e src, input logic ybit);
    logic r;
    case (src)
      BSRC_ZERO: r = 1'b0;
      BSRC_Y:    r = ybit;
      BSRC_NOTY: r = ~ybit;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic logic_bit(input lop_e op, input logic xb, input logic yb);
    logic r;
    case (op)
      LOP_AND: r = xb & yb;
      LOP_OR:  r = xb | yb;
      LOP_XOR: r = xb ^ yb;
      default: r = ~xb;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nib_alu_bsel.sv
module nib_alu_bsel
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  bsrc_e          src,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   b
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = bsel_bit(src, y[i]);
  end

endmodule

// File: rtl/nib_alu_adder.sv
module nib_alu_adder
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign sum[i]     = fa_sum(a[i], b[i], carry[i]);
    assign carry[i+1] = fa_carry(a[i], b[i], carry[i]);
  end

  assign cout = carry[W];

endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  lop_e         op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] r
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r[i] = logic_bit(op, x[i], y[i]);
  end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     g,
  output logic             cout
);

  // Named internal events, visible to the bound checker
  logic         use_logic;
  bsrc_e        bsrc;
  lop_e         lop;
  logic         carry_in;
  logic [W-1:0] b_opnd;
  logic [W-1:0] arith_res;
  logic         arith_cout;
  logic [W-1:0] logic_res;

  assign use_logic = sel[3];
  assign bsrc      = bsrc_e'(sel[2:1]);
  assign lop       = lop_e'(sel[1:0]);
  assign carry_in  = sel[0];

  nib_alu_bsel #(.W(W)) u_bsel (
    .src (bsrc),
    .y   (y),
    .b   (b_opnd)
  );

  nib_alu_adder #(.W(W)) u_adder (
    .a    (x),
    .b    (b_opnd),
    .cin  (carry_in),
    .sum  (arith_res),
    .cout (arith_cout)
  );

  nib_alu_logic #(.W(W)) u_logic (
    .op (lop),
    .x  (x),
    .y  (y),
    .r  (logic_res)
  );

  // Output multiplexer: one section's result is kept, the other discarded
  always_comb begin
    if (use_logic) begin
      g    = logic_res;
      cout = 1'b0;
    end else begin
      g    = arith_res;
      cout = arith_cout;
    end
  end

endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] x,
  input logic [W-1:0] y,
  input logic [3:0]   sel,
  input logic [W-1:0] g,
  input logic         cout,
  input logic [W-1:0] b_opnd,
  input logic [W-1:0] arith_res,
  input logic [W-1:0] logic_res
);

  always_comb begin
    if (sel[3]) begin
      assert_mux_logic_R1: assert (g == logic_res)
        else $error("logic path not selected");
      assert_cout_zero_R7: assert (cout == 1'b0)
        else $error("carry-out set during logic function");
      if (sel[1:0] == 2'b11) begin
        assert_notx_R6: assert (g == ~x)
          else $error("inverse of x wrong");
      end
    end else begin
      assert_mux_arith_R1: assert (g == arith_res)
        else $error("arithmetic path not selected");
      assert_full_sum_R8: assert ({cout, g} == ({1'b0, x} + {1'b0, b_opnd} + {{W{1'b0}}, sel[0]}))
        else $error("carry and result differ from full sum");
      if (sel[2:0] == 3'b000 || sel[2:0] == 3'b111) begin
        assert_pass_R2: assert (g == x)
          else $error("pass code altered x");
      end
      if (sel[2:1] == 2'b10) begin
        assert_inv_opnd_R4: assert (b_opnd == ~y)
          else $error("second operand not inverted y");
      end
    end
  end

endmodule

bind nib_alu nib_alu_chk #(.W(W)) u_chk (
  .x         (x),
  .y         (y),
  .sel       (sel),
  .g         (g),
  .cout      (cout),
  .b_opnd    (b_opnd),
  .arith_res (arith_res),
  .logic_res (logic_res)
);

// File: tb/nib_alu_tb.sv
module nib_alu_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [3:0]   sel = '0;
  wire  [W-1:0] g;
  wire          cout;

  nib_alu #(.W(W)) u_dut (.x(x), .y(y), .sel(sel), .g(g), .cout(cout));

  typedef struct {
    logic [3:0] xi, yi, si, eg;
    logic       ec;
    string      tag;
  } item_t;

  item_t sbq[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic item_t model(input logic [3:0] xv, input logic [3:0] yv,
                                  input logic [3:0] sv);
    item_t it;
    int a, bb, r;
    a = int'(xv);
    bb = int'(yv);
    it.xi = xv; it.yi = yv; it.si = sv;
    if (sv[3]) begin
      case (sv[1:0])
        2'b00: it.eg = xv & yv;
        2'b01: it.eg = xv | yv;
        2'b10: it.eg = xv ^ yv;
        default: it.eg = ~xv;
      endcase
      it.ec = 1'b0;
      it.tag = "R6";
    end else begin
      case (sv[2:0])
        3'd0: begin r = a;               it.tag = "R2"; end
        3'd1: begin r = a + 1;           it.tag = "R3"; end
        3'd2: begin r = a + bb;          it.tag = "R3"; end
        3'd3: begin r = a + bb + 1;      it.tag = "R3"; end
        3'd4: begin r = a + (15 - bb);   it.tag = "R4"; end
        3'd5: begin r = a + (16 - bb);   it.tag = "R4"; end
        3'd6: begin r = a + 15;          it.tag = "R5"; end
        default: begin r = a + 16;       it.tag = "R2"; end
      endcase
      it.eg = 4'(r % 16);
      it.ec = (r >= 16);
    end
    return it;
  endfunction

  task automatic check(input string tag, input string what, input logic [3:0] act,
                       input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] xv, input logic [3:0] yv, input logic [3:0] sv,
                       input string tag_over);
    item_t it;
    @(posedge clk);
    x = xv; y = yv; sel = sv;
    it = model(xv, yv, sv);
    if (tag_over != "") it.tag = tag_over;
    sbq.push_back(it);
  endtask

  // Monitor: pops expected items half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, $sformatf("g x=%h y=%h s=%h", it.xi, it.yi, it.si), g, it.eg);
        check(it.si[3] ? "R7" : it.tag,
              $sformatf("cout x=%h y=%h s=%h", it.xi, it.yi, it.si),
              {3'b0, cout}, {3'b0, it.ec});
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "reset-state g", g, 4'h0);
    check("R2", "reset-state cout", {3'b0, cout}, 4'h0);
    rst_n = 1'b1;

    // Corner cases called out by the requirements
    drive(4'hF, 4'h0, 4'b0001, "R8");   // wrap: 0, carry 1
    drive(4'hF, 4'h1, 4'b0010, "R8");   // 15+1 wraps
    drive(4'h0, 4'h0, 4'b0110, "R5");   // 0-1 = F, carry 0
    drive(4'h7, 4'h7, 4'b0101, "R4");   // x-y = 0, carry 1
    drive(4'h3, 4'h9, 4'b0101, "R4");   // borrow, carry 0
    drive(4'hA, 4'h5, 4'b0111, "R2");   // pass with carry 1
    drive(4'hC, 4'hA, 4'b1000, "R6");   // and
    drive(4'hC, 4'hA, 4'b1100, "R6");   // and, sel[2] set
    drive(4'h9, 4'h0, 4'b1111, "R7");   // not x
    drive(4'h5, 4'h3, 4'b1010, "R1");   // logic path chosen over adder

    // Exhaustive sweep of all operand and select combinations
    for (int s = 0; s < 16; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(4'(a), 4'(b), 4'(s), "");

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);

    // R9: outputs follow inputs with no clock edge in between
    @(negedge clk);
    x = 4'h5; y = 4'h3; sel = 4'b0010;
    #0.5;
    check("R9", "no-edge add", g, 4'h8);
    x = 4'h9;
    #0.5;
    check("R9", "no-edge update", g, 4'hC);

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

endmodule